// File: doc/BRIEF.md
# Prioritized Interrupt Dispatcher

This block decides which interrupt a small 8-bit processor core services next. It holds an 8-bit enable register and an 8-bit pending-flag register. Both can be read and written over a simple byte bus. Peripherals raise flags with one-cycle request pulses. The block also holds the core's master enable and its halted state. Out of scope are stack pushes and instruction execution.

A source becomes a candidate only when its bit is set in both the enable register and the flag register. When the master enable is on and the block is not already waiting on the core, it takes the lowest-numbered candidate. In the same step it clears that source's flag bit, clears the master enable and releases halt. It then raises a service request carrying a fixed 16-bit vector. The request stays up until the core acknowledges it.

A pending, enabled source always releases halt. If the master enable is off, no dispatch follows.

Top module: `intr_dispatch`

## Requirements
- R1: After reset the enable register is 0x00, the flag register reads 0xE0, the master enable is 0, halted is 0 and no service request is raised.
- R2: A bus write with busWe=1 to address 0xFFFF loads all 8 enable bits. A write to 0xFF0F loads flag bits 4..0. Reads are combinational. Address 0xFF0F returns {3'b111, flag[4:0]}, address 0xFFFF returns the enable register, and any other address returns 0x00.
- R3: reqIn[i]=1 sets flag bit i at the clock edge. When a flag write happens in the same cycle, the written value is applied first and the requests are ORed in afterwards.
- R4: A dispatch starts only if all three hold: the master enable is 1, no request is outstanding, and some source i in 0..2 has enable bit i and flag bit i both set. The service request output rises one cycle after that condition.
- R5: Source 0 wins over source 1, and source 1 wins over source 2. One source is taken per dispatch. The vectors are 0x0040 for bit 0, 0x0048 for bit 1 and 0x0050 for bit 2.
- R6: A dispatch clears only the flag bit of the serviced source and clears the master enable. A request pulse for that same bit in the same cycle sets it again.
- R7: svcReq and svcVector hold until svcAck is 1 at a clock edge. svcReq is 0 in the cycle after that edge. No other dispatch starts while a request is outstanding.
- R8: haltEnter=1 sets halted at the next edge. Halted is cleared at the edge after any source 0..2 is both enabled and flagged, whatever the master enable. A pending source wins over haltEnter in the same cycle.
- R9: Flag bits 3 and 4 and enable bits 3..7 are stored and read back. They never cause a dispatch and never release halt.
- R10: imeSet=1 sets the master enable. imeClr=1 clears it, and the clear wins when both are 1. A dispatch clears it even when imeSet is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Bus address for reads and writes |
| busWe | input | 1 | Bus write strobe |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data (combinational) |
| reqIn | input | 3 | Peripheral request pulses, one per source |
| imeSet | input | 1 | Set master enable |
| imeClr | input | 1 | Clear master enable |
| haltEnter | input | 1 | Core enters the halted state |
| svcAck | input | 1 | Core accepts the outstanding service request |
| svcReq | output | 1 | Service request to the core |
| svcVector | output | 16 | Vector address of the serviced source |
| imeOut | output | 1 | Current master enable |
| halted | output | 1 | Current halted state |

## Verification
The assertions accept an acknowledge at any time. An acknowledge while nothing is outstanding is taken to have no effect, so the stimulus drives svcAck freely, including with no request up. The assertions also assume the master enable is raised only through imeSet. For that reason the bench never expects a dispatch without a prior set, and it mixes imeSet and imeClr pulses so that both the collision case and the dispatch-wins case occur. Requests, bus writes to both registers and halt entries are spread at random across cycles. Because they land at random, they hit the same-cycle merges that the requirements single out.

// File: rtl/intr_dispatch_pkg.sv
`timescale 1ns/1ps
package intr_dispatch_pkg;
  localparam int REG_W   = 8;   // bus-visible register width
  localparam int STORE_W = 5;   // stored flag bits; the rest read as ones

  typedef struct packed {
    logic               take;     // a dispatch happens at this edge
    logic [STORE_W-1:0] clrMask;  // flag bit to clear for the serviced source
    logic               wake;     // some enabled source is pending
  } ctlStrobe_t;
endpackage

// File: rtl/intr_dispatch_dp.sv
`timescale 1ns/1ps
module intr_dispatch_dp
  import intr_dispatch_pkg::*;
#(
  parameter int                NUM_SRC   = 3,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] ENAB_ADDR = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]   busRdata,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               imeSet,
  input  logic               imeClr,
  input  logic               haltEnter,
  input  ctlStrobe_t         strobe,
  output logic [NUM_SRC-1:0] ieLo,
  output logic [NUM_SRC-1:0] ifLo,
  output logic               imeQ,
  output logic               haltQ
);
  localparam int ONES_W = REG_W - STORE_W;

  logic [REG_W-1:0]   ieReg;
  logic [STORE_W-1:0] ifReg;
  logic [STORE_W-1:0] ifNext;
  logic [STORE_W-1:0] reqExt;
  logic               flagHit;
  logic               enabHit;

  assign flagHit = (busAddr == FLAG_ADDR);
  assign enabHit = (busAddr == ENAB_ADDR);

  // widen request pulses to the stored flag width
  for (genvar g = 0; g < STORE_W; g++) begin : g_req
    if (g < NUM_SRC) begin : g_live
      assign reqExt[g] = reqIn[g];
    end else begin : g_dead
      assign reqExt[g] = 1'b0;
    end
  end

  // bus write first, then dispatch clear, then requests ORed in
  always_comb begin
    ifNext = (busWe && flagHit) ? busWdata[STORE_W-1:0] : ifReg;
    ifNext = (ifNext & ~strobe.clrMask) | reqExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieReg <= '0;
      ifReg <= '0;
    end else begin
      ifReg <= ifNext;
      if (busWe && enabHit) ieReg <= busWdata;
    end
  end

  // master enable: dispatch clear, then explicit clear, then set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            imeQ <= 1'b0;
    else if (strobe.take) imeQ <= 1'b0;
    else if (imeClr)      imeQ <= 1'b0;
    else if (imeSet)      imeQ <= 1'b1;
  end

  // halt: any enabled pending source releases it (a take implies wake)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            haltQ <= 1'b0;
    else if (strobe.wake) haltQ <= 1'b0;
    else if (haltEnter)   haltQ <= 1'b1;
  end

  always_comb begin
    if (flagHit)      busRdata = {{ONES_W{1'b1}}, ifReg};
    else if (enabHit) busRdata = ieReg;
    else              busRdata = '0;
  end

  assign ieLo = ieReg[NUM_SRC-1:0];
  assign ifLo = ifReg[NUM_SRC-1:0];
endmodule

// File: rtl/intr_dispatch_ctl.sv
`timescale 1ns/1ps
module intr_dispatch_ctl
  import intr_dispatch_pkg::*;
#(
  parameter int                NUM_SRC  = 3,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
  parameter int                VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] ieLo,
  input  logic [NUM_SRC-1:0] ifLo,
  input  logic               imeQ,
  input  logic               svcAck,
  output ctlStrobe_t         strobe,
  output logic               svcReq,
  output logic [ADDR_W-1:0]  svcVector
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  typedef enum logic {ST_IDLE, ST_WAIT} ctlState_t;

  ctlState_t          state;
  logic [NUM_SRC-1:0] pend;
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic               take;
  logic [ADDR_W-1:0]  vecNext;

  assign pend = ieLo & ifLo;

  // fixed priority: scan downward so the lowest pending bit is kept
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign take    = hit && imeQ && (state == ST_IDLE);
  assign vecNext = VEC_BASE + (ADDR_W'(idx) * ADDR_W'(VEC_STEP));

  always_comb begin
    strobe         = '0;
    strobe.take    = take;
    strobe.wake    = hit;
    if (take) strobe.clrMask[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      svcVector <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          state     <= ST_WAIT;
          svcVector <= vecNext;
        end
        ST_WAIT: if (svcAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign svcReq = (state == ST_WAIT);
endmodule

// File: rtl/intr_dispatch.sv
`timescale 1ns/1ps
module intr_dispatch
  import intr_dispatch_pkg::*;
#(
  parameter int                NUM_SRC   = 3,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] ENAB_ADDR = 16'hFFFF,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0040,
  parameter int                VEC_STEP  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]   busRdata,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               imeSet,
  input  logic               imeClr,
  input  logic               haltEnter,
  input  logic               svcAck,
  output logic               svcReq,
  output logic [ADDR_W-1:0]  svcVector,
  output logic               imeOut,
  output logic               halted
);
  ctlStrobe_t         strobe;
  logic [NUM_SRC-1:0] ieLo;
  logic [NUM_SRC-1:0] ifLo;

  intr_dispatch_dp #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
    .FLAG_ADDR(FLAG_ADDR), .ENAB_ADDR(ENAB_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .reqIn(reqIn), .imeSet(imeSet), .imeClr(imeClr), .haltEnter(haltEnter),
    .strobe(strobe), .ieLo(ieLo), .ifLo(ifLo), .imeQ(imeOut), .haltQ(halted)
  );

  intr_dispatch_ctl #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .ieLo(ieLo), .ifLo(ifLo), .imeQ(imeOut), .svcAck(svcAck),
    .strobe(strobe), .svcReq(svcReq), .svcVector(svcVector)
  );
endmodule

// File: rtl/intr_dispatch_chk.sv
`timescale 1ns/1ps
module intr_dispatch_chk #(
  parameter int                NUM_SRC  = 3,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
  parameter int                VEC_STEP = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              svcReq,
  input logic              svcAck,
  input logic [ADDR_W-1:0] svcVector,
  input logic              imeOut,
  input logic              halted
);
  // R4
  dispatch_needs_ime_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcReq) |-> $past(imeOut));

  // R6
  dispatch_clears_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcReq) |-> (!imeOut && !halted));

  // R7
  request_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcReq && !svcAck) |=> (svcReq && $stable(svcVector)));

  // R7
  request_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcReq && svcAck) |=> !svcReq);

  // R5
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> (((svcVector - VEC_BASE) % ADDR_W'(VEC_STEP)) == '0 &&
                (svcVector - VEC_BASE) < ADDR_W'(NUM_SRC * VEC_STEP)));
endmodule

bind intr_dispatch intr_dispatch_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rstN(rstN), .svcReq(svcReq), .svcAck(svcAck),
  .svcVector(svcVector), .imeOut(imeOut), .halted(halted)
);

// File: tb/sim_intr_dispatch.sv
`timescale 1ns/1ps
module sim_intr_dispatch;
  localparam logic [15:0] FLAG = 16'hFF0F;
  localparam logic [15:0] ENAB = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [2:0]  reqIn = '0;
  logic        imeSet = 1'b0, imeClr = 1'b0, haltEnter = 1'b0, svcAck = 1'b0;
  logic        svcReq;
  logic [15:0] svcVector;
  logic        imeOut, halted;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0]  mIe = '0;
  logic [4:0]  mIf = '0;
  logic        mIme = 1'b0, mHalt = 1'b0, mReq = 1'b0;
  logic [15:0] mVec = '0;

  always #10 clk = ~clk;  // 50 MHz

  intr_dispatch u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .reqIn(reqIn),
    .imeSet(imeSet), .imeClr(imeClr), .haltEnter(haltEnter),
    .svcAck(svcAck), .svcReq(svcReq), .svcVector(svcVector),
    .imeOut(imeOut), .halted(halted)
  );

  function automatic logic [7:0] expRead(logic [15:0] a);
    if (a == FLAG) return {3'b111, mIf};
    if (a == ENAB) return mIe;
    return 8'h00;
  endfunction

  task automatic check(string tag, int got, int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idleInputs();
    busWe = 1'b0; reqIn = '0; imeSet = 1'b0; imeClr = 1'b0;
    haltEnter = 1'b0; svcAck = 1'b0;
  endtask

  // one clock: advance the reference from current inputs, then compare
  task automatic tick();
    logic [2:0]  pend;
    logic        take;
    int          idx;
    logic [4:0]  nIf;
    logic [7:0]  nIe;
    logic        nIme, nHalt, nReq;
    logic [15:0] nVec;
    pend = mIe[2:0] & mIf[2:0];
    take = !mReq && mIme && (pend != 0);
    idx = pend[0] ? 0 : (pend[1] ? 1 : 2);
    nIf = (busWe && busAddr == FLAG) ? busWdata[4:0] : mIf;
    if (take) nIf[idx] = 1'b0;
    nIf = nIf | {2'b00, reqIn};
    nIe = (busWe && busAddr == ENAB) ? busWdata : mIe;
    nIme = take ? 1'b0 : (imeClr ? 1'b0 : (imeSet ? 1'b1 : mIme));
    nHalt = (pend != 0) ? 1'b0 : (haltEnter ? 1'b1 : mHalt);
    nReq = take ? 1'b1 : ((mReq && svcAck) ? 1'b0 : mReq);
    nVec = take ? 16'(16'h0040 + 8 * idx) : mVec;
    @(posedge clk);
    mIf = nIf; mIe = nIe; mIme = nIme; mHalt = nHalt; mReq = nReq; mVec = nVec;
    @(negedge clk);
    check("R7 svcReq", svcReq, mReq);
    if (mReq) check("R5 svcVector", svcVector, mVec);
    check("R10 imeOut", imeOut, mIme);
    check("R8 halted", halted, mHalt);
    check("R2 busRdata", busRdata, expRead(busAddr));
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    busAddr = a; busWe = 1'b1; busWdata = d;
    tick();
    idleInputs();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog R7: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 svcReq", svcReq, 0);
    check("R1 imeOut", imeOut, 0);
    check("R1 halted", halted, 0);
    busAddr = FLAG; #1 check("R1 flag read", busRdata, 8'hE0);
    busAddr = ENAB; #1 check("R1 enable read", busRdata, 8'h00);
    rstN = 1'b1;

    // R2 register access
    wr(ENAB, 8'hFF);
    busAddr = ENAB; #1 check("R2 enable readback", busRdata, 8'hFF);
    busAddr = 16'h1234; #1 check("R2 other address", busRdata, 8'h00);
    wr(FLAG, 8'hFF);
    busAddr = FLAG; #1 check("R2 flag readback", busRdata, 8'hFF);
    wr(FLAG, 8'h00);
    busAddr = FLAG; #1 check("R2 flag cleared", busRdata, 8'hE0);

    // R3 write then request merge
    reqIn = 3'b100;
    wr(FLAG, 8'h01);
    busAddr = FLAG; #1 check("R3 merge", busRdata, 8'hE5);
    check("R4 no dispatch without ime", svcReq, 0);

    // R4 R5 R6: bits 0 and 2 pending, bit 0 wins
    imeSet = 1'b1; tick(); idleInputs();
    check("R4 ime set", imeOut, 1);
    tick();
    check("R4 dispatch", svcReq, 1);
    check("R5 vector bit0", svcVector, 16'h0040);
    busAddr = FLAG; #1 check("R6 flag bit cleared", busRdata, 8'hE4);
    check("R6 ime cleared", imeOut, 0);
    // R7 hold without ack, one pending remains
    imeSet = 1'b1; tick(); idleInputs();
    tick(); tick();
    check("R7 held", svcReq, 1);
    check("R7 vector stable", svcVector, 16'h0040);
    svcAck = 1'b1; tick(); idleInputs();
    check("R7 dropped after ack", svcReq, 0);
    tick();
    check("R5 vector bit2", svcVector, 16'h0050);
    svcAck = 1'b1; tick(); idleInputs();

    // R5 bit1 beats bit2
    reqIn = 3'b110; tick(); idleInputs();
    imeSet = 1'b1; tick(); idleInputs();
    tick();
    check("R5 vector bit1", svcVector, 16'h0048);
    svcAck = 1'b1; tick(); idleInputs();
    imeSet = 1'b1; tick(); idleInputs();
    tick();
    svcAck = 1'b1; tick(); idleInputs();

    // R9 unimplemented flag bits never dispatch nor wake
    haltEnter = 1'b1; tick(); idleInputs();
    wr(FLAG, 8'h18);
    imeSet = 1'b1; tick(); idleInputs();
    tick(); tick();
    check("R9 no dispatch", svcReq, 0);
    check("R9 still halted", halted, 1);
    busAddr = FLAG; #1 check("R9 bits kept", busRdata, 8'hF8);

    // R8 wake without dispatch when ime clear
    imeClr = 1'b1; tick(); idleInputs();
    reqIn = 3'b010; tick(); idleInputs();
    tick();
    check("R8 woke", halted, 0);
    check("R8 no dispatch", svcReq, 0);

    // R10 set and clear together
    wr(FLAG, 8'h00);
    imeSet = 1'b1; imeClr = 1'b1; tick(); idleInputs();
    check("R10 clear wins", imeOut, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom;
      reqIn     = (r[2:0] == 0) ? 3'($urandom) : 3'b000;
      busWe     = (r[5:3] == 0);
      case (r[7:6])
        2'd0: busAddr = FLAG;
        2'd1: busAddr = ENAB;
        2'd2: busAddr = FLAG;
        default: busAddr = 16'($urandom);
      endcase
      busWdata  = 8'($urandom);
      imeSet    = ($urandom % 6) == 0;
      imeClr    = ($urandom % 20) == 0;
      haltEnter = ($urandom % 10) == 0;
      svcAck    = ($urandom % 3) == 0;
      tick();
      idleInputs();
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule